// File: doc/BRIEF.md
# Sample-Period Divider with Phase Nudge

The block divides a master clock down to the conversion sample strobe. A down-counter is loaded with a main divide value and produces a strobe each time it reaches zero, so a sample period lasts a programmable number of master-clock cycles. A phase nudge moves the sampling instant. A per-frame request asks for one period to be shortened (advance) or lengthened (retard) by the value of an adjustment register.

A request moves only the one period that follows the next period boundary. Every later period returns to the nominal length. To drift the sampling phase steadily, the request has to be repeated every frame. If it is sent only once, the strobe train shifts by a single step and then looks unchanged.

For example, an adjustment of 10 on a master clock near 10.4 MHz moves one 125 µs period by roughly 0.96 µs. A flag marks every cycle of a period that was adjusted.

Top module: `sample_period_divider`

## Requirements
- R1: With no adjustment pending, strobes come exactly N cycles apart, where N is the main divide value, and each strobe is one cycle wide.
- R2: Request code 01 (advance) makes the period started at the next boundary N−A cycles long, where A is the adjustment value.
- R3: Request code 10 (retard) makes the period started at the next boundary N+A cycles long.
- R4: Only one period is adjusted per request. The period after an adjusted one is nominal unless a new request arrives.
- R5: A request is taken at the first strobe that follows the cycle in which it is presented. A request presented in a strobe cycle waits for the boundary after that.
- R6: Request codes 00 and 11 have no effect on period length or on the flag.
- R7: Several requests in one period give at most one adjustment, and the last valid code presented wins.
- R8: An advance with A ≥ N gives a period of one cycle, never zero.
- R9: A main divide value of 0 is treated as 1, both for nominal periods and as the base of an adjustment.
- R10: adj_active is high on every cycle of an adjusted period, up to and including its closing strobe, and low on every cycle of a nominal period.
- R11: Reset clears any pending request and lowers adj_active. The first strobe appears on the Nth cycle after the first clock edge that sees reset low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rst | input | 1 | synchronous active-high reset |
| div_val | input | CNT_W | main divide value N, sampled at each period boundary |
| adj_val | input | ADJ_W | adjustment magnitude A, sampled at each period boundary |
| req_valid | input | 1 | qualifies req_code for one cycle |
| req_code | input | 2 | 00 none, 01 advance, 10 retard, 11 none |
| sample_strobe | output | 1 | one-cycle pulse that ends each sample period |
| adj_active | output | 1 | high during a period whose length was adjusted |

## Verification
The bench builds the block with CNT_W = 6 and ADJ_W = 4. With these widths the random divide values stay short, so many hundreds of boundaries fit in a short run. The adjustment range is also wide enough compared with the divide range that advance clamping, zero divide values and the widest retard (63+15) come up often. Directed sequences at N = 10 measure exact period lengths around each request placement. A random phase then compares the strobe and flag on every cycle with a bench model.

// File: rtl/spd_pkg.sv
package spd_pkg;

    typedef enum logic [1:0] {
        REQ_IDLE   = 2'b00,
        REQ_ADV    = 2'b01,
        REQ_RET    = 2'b10,
        REQ_IDLE_B = 2'b11
    } req_code_e;

    typedef enum logic [1:0] {
        DIR_NONE    = 2'b00,
        DIR_SHORTEN = 2'b01,
        DIR_LENGTHEN = 2'b10
    } adj_dir_e;

    function automatic adj_dir_e decode_req(input logic [1:0] code);
        adj_dir_e d;
        case (req_code_e'(code))
            REQ_ADV: d = DIR_SHORTEN;
            REQ_RET: d = DIR_LENGTHEN;
            default: d = DIR_NONE;
        endcase
        return d;
    endfunction

    function automatic int unsigned len_width(input int unsigned cw, input int unsigned aw);
        return ((cw > aw) ? cw : aw) + 1;
    endfunction

endpackage

// File: rtl/spd_req_latch.sv
module spd_req_latch
    import spd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic [1:0] req_code,
    input  logic       boundary,
    output adj_dir_e   pend_dir
);
    adj_dir_e new_dir;
    assign new_dir = decode_req(req_code);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_dir <= DIR_NONE;
        end else if (req_valid && new_dir != DIR_NONE) begin
            pend_dir <= new_dir;
        end else if (boundary) begin
            pend_dir <= DIR_NONE;
        end
    end
endmodule

// File: rtl/spd_len_calc.sv
module spd_len_calc
    import spd_pkg::*;
#(
    parameter int unsigned CNT_W = 8,
    parameter int unsigned ADJ_W = 4,
    localparam int unsigned LEN_W = len_width(CNT_W, ADJ_W)
) (
    input  logic [CNT_W-1:0] div_val,
    input  logic [ADJ_W-1:0] adj_val,
    input  adj_dir_e         dir,
    output logic [LEN_W-1:0] nom_len,
    output logic [LEN_W-1:0] load_len
);
    logic [LEN_W-1:0] base;
    logic [LEN_W-1:0] adj_ext;

    always_comb begin
        base    = (div_val == '0) ? LEN_W'(1) : LEN_W'(div_val);
        adj_ext = LEN_W'(adj_val);
        nom_len = base;
        case (dir)
            DIR_SHORTEN:  load_len = (base > adj_ext) ? (base - adj_ext) : LEN_W'(1);
            DIR_LENGTHEN: load_len = base + adj_ext;
            default:      load_len = base;
        endcase
    end
endmodule

// File: rtl/spd_counter.sv
module spd_counter #(
    parameter int unsigned LEN_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LEN_W-1:0] rst_len,
    input  logic [LEN_W-1:0] load_len,
    output logic [LEN_W-1:0] cnt,
    output logic             strobe
);
    assign strobe = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= rst_len;
        end else if (strobe) begin
            cnt <= load_len - LEN_W'(1);
        end else begin
            cnt <= cnt - LEN_W'(1);
        end
    end
endmodule

// File: rtl/sample_period_divider.sv
module sample_period_divider
    import spd_pkg::*;
#(
    parameter int unsigned CNT_W = 8,
    parameter int unsigned ADJ_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] div_val,
    input  logic [ADJ_W-1:0] adj_val,
    input  logic             req_valid,
    input  logic [1:0]       req_code,
    output logic             sample_strobe,
    output logic             adj_active
);
    localparam int unsigned LEN_W = len_width(CNT_W, ADJ_W);

    adj_dir_e         pend_dir;
    logic [LEN_W-1:0] nom_len;
    logic [LEN_W-1:0] load_len;
    logic [LEN_W-1:0] cnt;
    logic             strobe;

    spd_req_latch u_req (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_code (req_code),
        .boundary (strobe),
        .pend_dir (pend_dir)
    );

    spd_len_calc #(.CNT_W(CNT_W), .ADJ_W(ADJ_W)) u_len (
        .div_val (div_val),
        .adj_val (adj_val),
        .dir     (pend_dir),
        .nom_len (nom_len),
        .load_len(load_len)
    );

    spd_counter #(.LEN_W(LEN_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .rst_len (nom_len),
        .load_len(load_len),
        .cnt     (cnt),
        .strobe  (strobe)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            adj_active <= 1'b0;
        end else if (strobe) begin
            adj_active <= (pend_dir != DIR_NONE);
        end
    end

    assign sample_strobe = strobe;
endmodule

// File: rtl/sample_period_divider_chk.sv
module sample_period_divider_chk
    import spd_pkg::*;
#(
    parameter int unsigned LEN_W = 9
) (
    input logic             clk,
    input logic             rst,
    input logic             sample_strobe,
    input logic             adj_active,
    input adj_dir_e         pend_dir,
    input logic [LEN_W-1:0] cnt,
    input logic [LEN_W-1:0] load_len
);
    // R1
    cnt_down_chk: assert property (@(posedge clk) disable iff (rst)
        !sample_strobe |=> cnt == $past(cnt) - LEN_W'(1));

    // R8
    len_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        sample_strobe |-> load_len != '0);

    // R10
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sample_strobe |=> $stable(adj_active));

    // R4
    nominal_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (sample_strobe && pend_dir == DIR_NONE) |=> !adj_active);

    // R5
    applied_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (sample_strobe && pend_dir != DIR_NONE) |=> adj_active);

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!adj_active && pend_dir == DIR_NONE));
endmodule

bind sample_period_divider sample_period_divider_chk #(.LEN_W(LEN_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .sample_strobe(sample_strobe),
    .adj_active   (adj_active),
    .pend_dir     (pend_dir),
    .cnt          (cnt),
    .load_len     (load_len)
);

// File: tb/sample_period_divider_test.sv
`timescale 1ns/1ps
module sample_period_divider_test;
    localparam int CW = 6;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CW-1:0] div_val = CW'(10);
    logic [AW-1:0] adj_val = AW'(3);
    logic          req_valid = 1'b0;
    logic [1:0]    req_code = 2'b00;
    logic          sample_strobe;
    logic          adj_active;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    bit cmp_on = 0;

    always #4 clk = ~clk;

    sample_period_divider #(.CNT_W(CW), .ADJ_W(AW)) uut (
        .clk(clk), .rst(rst), .div_val(div_val), .adj_val(adj_val),
        .req_valid(req_valid), .req_code(req_code),
        .sample_strobe(sample_strobe), .adj_active(adj_active)
    );

    function automatic int nom(input int d);
        return (d == 0) ? 1 : d;
    endfunction

    function automatic int exp_len(input int d, input int a, input int code);
        int b = nom(d);
        if (code == 1) return (b > a) ? b - a : 1;
        if (code == 2) return b + a;
        return b;
    endfunction

    // bench model of the period sequence, built from the requirements
    int m_cnt = 0;
    int m_pend = 0;
    bit m_act = 0;
    always @(posedge clk) begin
        bit bnd;
        if (rst) begin
            m_cnt = nom(int'(div_val));
            m_pend = 0;
            m_act = 0;
        end else begin
            bnd = (m_cnt == 0);
            if (bnd) begin
                m_cnt = exp_len(int'(div_val), int'(adj_val), m_pend) - 1;
                m_act = (m_pend != 0);
            end else begin
                m_cnt = m_cnt - 1;
            end
            if (req_valid && (req_code == 2'b01 || req_code == 2'b10)) m_pend = int'(req_code);
            else if (bnd) m_pend = 0;
        end
    end

    task automatic check_int(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            check_int("R1 R10 random strobe", int'(sample_strobe), int'(m_cnt == 0));
            check_int("R10 random flag", int'(adj_active), int'(m_act));
        end
    end

    task automatic run_period(input int k1, input logic [1:0] c1,
                              input int k2, input logic [1:0] c2,
                              output int n, output int act);
        n = 0;
        act = 0;
        do begin
            req_valid = (n == k1) || (n == k2);
            req_code = (n == k2) ? c2 : c1;
            @(negedge clk);
            n++;
            if (adj_active) act = 1;
        end while (!sample_strobe && n < 500);
        req_valid = 1'b0;
        req_code = 2'b00;
    endtask

    task automatic wait_strobe();
        int g = 0;
        do begin
            @(negedge clk);
            g++;
        end while (!sample_strobe && g < 500);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int n, a;
        repeat (3) @(negedge clk);
        // R11 reset state
        check_int("R11 strobe in reset", int'(sample_strobe), 0);
        check_int("R11 flag in reset", int'(adj_active), 0);
        rst = 1'b0;
        n = 0;
        do begin @(negedge clk); n++; end while (!sample_strobe && n < 500);
        check_int("R11 first strobe delay", n, 10);

        run_period(-1, 2'b00, -1, 2'b00, n, a);
        check_int("R1 nominal length", n, 10);
        check_int("R1 nominal flag", a, 0);

        run_period(3, 2'b01, -1, 2'b00, n, a);
        check_int("R5 period holding request", n, 10);
        run_period(-1, 2'b00, -1, 2'b00, n, a);
        check_int("R2 advance length", n, 7);
        check_int("R10 advance flag", a, 1);
        run_period(-1, 2'b00, -1, 2'b00, n, a);
        check_int("R4 after advance", n, 10);
        check_int("R4 flag after advance", a, 0);

        run_period(0, 2'b10, -1, 2'b00, n, a);
        check_int("R5 strobe-cycle request deferred", n, 10);
        run_period(-1, 2'b00, -1, 2'b00, n, a);
        check_int("R3 retard length", n, 13);
        check_int("R10 retard flag", a, 1);

        run_period(4, 2'b00, 6, 2'b11, n, a);
        run_period(-1, 2'b00, -1, 2'b00, n, a);
        check_int("R6 codes 00 and 11 length", n, 10);
        check_int("R6 codes 00 and 11 flag", a, 0);

        run_period(2, 2'b01, 5, 2'b10, n, a);
        run_period(-1, 2'b00, -1, 2'b00, n, a);
        check_int("R7 last request wins", n, 13);
        run_period(-1, 2'b00, -1, 2'b00, n, a);
        check_int("R7 single adjustment", n, 10);

        adj_val = AW'(12);
        run_period(3, 2'b01, -1, 2'b00, n, a);
        run_period(-1, 2'b00, -1, 2'b00, n, a);
        check_int("R8 clamp length", n, 1);
        check_int("R8 clamp flag", a, 1);
        run_period(-1, 2'b00, -1, 2'b00, n, a);
        check_int("R8 after clamp", n, 10);

        div_val = '0;
        adj_val = AW'(3);
        run_period(-1, 2'b00, -1, 2'b00, n, a);
        run_period(-1, 2'b00, -1, 2'b00, n, a);
        check_int("R9 zero divide", n, 1);
        run_period(0, 2'b10, -1, 2'b00, n, a);
        run_period(-1, 2'b00, -1, 2'b00, n, a);
        check_int("R9 retard on zero divide", n, 4);

        div_val = CW'(10);
        run_period(-1, 2'b00, -1, 2'b00, n, a);
        run_period(-1, 2'b00, -1, 2'b00, n, a);
        // R11 reset drops a pending request
        req_valid = 1'b1; req_code = 2'b01;
        @(negedge clk);
        req_valid = 1'b0; req_code = 2'b00;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        n = 0; a = 0;
        do begin @(negedge clk); n++; if (adj_active) a = 1; end while (!sample_strobe && n < 500);
        check_int("R11 first period after reset", n, 10);
        run_period(-1, 2'b00, -1, 2'b00, n, a);
        check_int("R11 pending cleared", n, 10);
        check_int("R11 pending cleared flag", a, 0);

        // random phase against the bench model
        void'($urandom(32'd1234));
        @(negedge clk);
        cmp_on = 1;
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 39) == 0) div_val = CW'($urandom_range(0, 24));
            if ($urandom_range(0, 19) == 0) div_val = CW'($urandom_range(0, 63));
            if ($urandom_range(0, 9) == 0) adj_val = AW'($urandom_range(0, 15));
            req_valid = ($urandom_range(0, 9) < 3);
            req_code = 2'($urandom_range(0, 3));
            @(negedge clk);
        end
        req_valid = 1'b0;
        cmp_on = 0;
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule